// File: doc/BRIEF.md
# Modem acquisition mode sequencer

This block drives the acquisition schedule of a data modem's receive front end. It runs on a bit-rate strobe and produces two 2-bit selections. One is the loop bandwidth of the clock-recovery circuit: Wide, Medium, Narrow or Hold. The other is the tracking mode of the signal level detector: Clamp, Lossy Peak, Peak Averaging or Hold. Two separate start pulses launch the schedules, one for the bit clock and one for the level path. The two paths run independently of each other and share only the frame-sync inputs.

After a start, each path first steps through its fast-acquisition modes and then settles on a residual selection taken from configuration. The length of the middle mode depends on a frame-sync search request. If a search is requested inside a short window after the start, the path holds that mode until a frame-sync detected pulse arrives. Otherwise the mode ends after a fixed number of bits. A busy flag on each path stays high until that path reaches its residual selection.

Top module: `acq_mode_seq`

## Requirements
- R1: After reset, `bw_busy` and `lvl_busy` are low, and each code output shows its configured residual value.
- R2: A `clk_start` pulse sets `bw_code` to Wide (2'd0) and raises `bw_busy` on the following cycle. It restarts the bandwidth schedule from that point, whatever state the path is in. A strobe in the start cycle itself is not counted.
- R3: If no search is seen in the bandwidth window, Wide lasts exactly 16 bit strobes after the start, and then `bw_code` becomes Medium (2'd1).
- R4: The bandwidth path is armed if `fs_search` is high in the start cycle, or in any later cycle up to and including the one carrying the 14th strobe after the start. An armed path keeps Wide, whatever the strobe count, until an `fs_found` cycle that comes after the cycle in which the search was seen. Medium follows on the next cycle.
- R5: Medium lasts exactly 30 bit strobes. The strobe in the cycle that entered Medium is not counted. After that, `bw_code` equals `cfg_bw_res` and `bw_busy` drops.
- R6: A `lvl_start` pulse sets `lvl_code` to Clamp (2'd0) and raises `lvl_busy` on the following cycle. It restarts the level schedule. Clamp lasts exactly 1 bit strobe, and then `lvl_code` becomes Lossy Peak (2'd1).
- R7: If no search is seen in the level window, Lossy Peak lasts exactly 30 bit strobes. After that, `lvl_code` equals `cfg_lvl_res` and `lvl_busy` drops.
- R8: The level path is armed if `fs_search` is high in the start cycle, or in any later cycle up to and including the one carrying the 28th strobe after the start. An armed level path keeps Lossy Peak until an `fs_found` cycle that comes after the search. The residual selection applies from the next cycle.
- R9: `fs_found` has no effect in the following cases: the path is unarmed, the path is in Clamp, Medium or residual, or the search has not yet been registered. `fs_search` has no effect once a path's window has closed.
- R10: Neither path's start, counters or mode affects the other path's outputs.
- R11: While a path is not busy, its code output follows its configuration field combinationally. The level residual may be Lossy Peak (2'd1) or Peak Averaging (2'd2), and the bandwidth residual may be any code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One-cycle pulse per received bit |
| clk_start | input | 1 | Starts the bandwidth schedule |
| lvl_start | input | 1 | Starts the level schedule |
| fs_search | input | 1 | Frame-sync search request |
| fs_found | input | 1 | Frame-sync detected pulse |
| cfg_bw_res | input | 2 | Residual loop bandwidth code |
| cfg_lvl_res | input | 2 | Residual level mode code |
| bw_code | output | 2 | Loop bandwidth: 0 Wide, 1 Medium, 2 Narrow, 3 Hold |
| bw_busy | output | 1 | Bandwidth schedule not yet residual |
| lvl_code | output | 2 | Level mode: 0 Clamp, 1 Lossy Peak, 2 Peak Averaging, 3 Hold |
| lvl_busy | output | 1 | Level schedule not yet residual |

## Verification
The hardest cases to reach lie at the edges of the search windows: a search that lands on the 14th or 28th strobe and arms the path, and one that lands on the next strobe and is ignored. A detection that arrives while the level path is still in Clamp is another such case. The bench places a single search pulse at every cycle offset from the start cycle to well past both windows, with a detection pulse at a fixed later cycle. It also runs a case where the detection comes one bit after the start. Strobe spacing is varied so that bit counts and cycle counts differ.

// File: rtl/acq_pkg.sv
package acq_pkg;

  typedef enum logic [1:0] {
    PH_A   = 2'd0,
    PH_B   = 2'd1,
    PH_C   = 2'd2,
    PH_RES = 2'd3
  } acq_phase_e;

  localparam logic [1:0] BW_WIDE   = 2'd0;
  localparam logic [1:0] BW_MEDIUM = 2'd1;
  localparam logic [1:0] LV_CLAMP  = 2'd0;
  localparam logic [1:0] LV_LOSSY  = 2'd1;

  // first phase after a start: the lead-in phase is skipped when its length is zero
  function automatic acq_phase_e entry_phase(input int len_a);
    return (len_a > 0) ? PH_A : PH_B;
  endfunction

  // phase that follows the conditional phase
  function automatic acq_phase_e after_hold(input int len_c);
    return (len_c > 0) ? PH_C : PH_RES;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/acq_win.sv
module acq_win #(
  parameter int WIN = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic start,
  input  logic fs_search,
  output logic armed
);
  localparam int WW = $clog2(WIN + 1);

  logic [WW-1:0] wcnt;
  logic          win_open;

  assign win_open = (wcnt < WW'(WIN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt  <= WW'(WIN);
      armed <= 1'b0;
    end else if (start) begin
      wcnt  <= '0;
      armed <= fs_search;
    end else begin
      if (bit_stb && win_open) wcnt <= wcnt + 1'b1;
      if (fs_search && win_open) armed <= 1'b1;
    end
  end

  AST_LATE_SEARCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !win_open) |=> $stable(armed)); // R9

endmodule

// File: rtl/acq_path.sv
module acq_path
  import acq_pkg::*;
#(
  parameter int         LEN_A  = 0,
  parameter int         LEN_B  = 16,
  parameter int         LEN_C  = 30,
  parameter int         WIN    = 14,
  parameter logic [1:0] CODE_A = 2'd0,
  parameter logic [1:0] CODE_B = 2'd0,
  parameter logic [1:0] CODE_C = 2'd1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb,
  input  logic       start,
  input  logic       fs_search,
  input  logic       fs_found,
  input  logic [1:0] res_code,
  output logic [1:0] code,
  output logic       busy
);
  localparam int         MAXL   = max3(LEN_A, LEN_B, LEN_C);
  localparam int         CW     = $clog2(MAXL + 1);
  localparam acq_phase_e FIRST  = entry_phase(LEN_A);
  localparam acq_phase_e POST_B = after_hold(LEN_C);

  function automatic logic [CW-1:0] last_idx(input int len);
    return (len > 0) ? CW'(len - 1) : '0;
  endfunction

  acq_phase_e    phase, nxt;
  logic [CW-1:0] cnt, cur_last;
  logic          armed, in_hold, fixed_end, hold_end, adv, cnt_en;

  acq_win #(.WIN(WIN)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb   (bit_stb),
    .start     (start),
    .fs_search (fs_search),
    .armed     (armed)
  );

  always_comb begin
    case (phase)
      PH_A:    cur_last = last_idx(LEN_A);
      PH_B:    cur_last = last_idx(LEN_B);
      PH_C:    cur_last = last_idx(LEN_C);
      default: cur_last = '0;
    endcase
  end

  always_comb begin
    case (phase)
      PH_A:    nxt = PH_B;
      PH_B:    nxt = POST_B;
      default: nxt = PH_RES;
    endcase
  end

  // named events for the checks
  assign in_hold   = (phase == PH_B) && armed;
  assign fixed_end = bit_stb && (phase != PH_RES) && !in_hold && (cnt == cur_last);
  assign hold_end  = in_hold && fs_found;
  assign adv       = fixed_end || hold_end;
  assign cnt_en    = bit_stb && (phase != PH_RES) && (cnt != '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_RES;
      cnt   <= '0;
    end else if (start) begin
      phase <= FIRST;
      cnt   <= '0;
    end else if (adv) begin
      phase <= nxt;
      cnt   <= '0;
    end else if (cnt_en) begin
      cnt   <= cnt + 1'b1;
    end
  end

  always_comb begin
    case (phase)
      PH_A:    code = CODE_A;
      PH_B:    code = CODE_B;
      PH_C:    code = CODE_C;
      default: code = res_code;
    endcase
  end

  assign busy = (phase != PH_RES);

  AST_START_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (phase == FIRST) && busy); // R2 R6

  AST_STEP_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !bit_stb && !fs_found) |=> $stable(phase)); // R3 R5 R7

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && in_hold && !fs_found) |=> (phase == PH_B)); // R4 R8

  AST_FOUND_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !bit_stb && !in_hold) |=> $stable(phase)); // R9

  AST_RES_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && (phase == PH_RES)) |=> (phase == PH_RES) && !busy); // R5 R7

endmodule

// File: rtl/acq_mode_seq.sv
module acq_mode_seq
  import acq_pkg::*;
#(
  parameter int BW_WIDE_BITS  = 16,
  parameter int BW_WIN_BITS   = 14,
  parameter int BW_MED_BITS   = 30,
  parameter int LV_CLAMP_BITS = 1,
  parameter int LV_WIN_BITS   = 28,
  parameter int LV_LOSSY_BITS = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb,
  input  logic       clk_start,
  input  logic       lvl_start,
  input  logic       fs_search,
  input  logic       fs_found,
  input  logic [1:0] cfg_bw_res,
  input  logic [1:0] cfg_lvl_res,
  output logic [1:0] bw_code,
  output logic       bw_busy,
  output logic [1:0] lvl_code,
  output logic       lvl_busy
);

  acq_path #(
    .LEN_A  (0),
    .LEN_B  (BW_WIDE_BITS),
    .LEN_C  (BW_MED_BITS),
    .WIN    (BW_WIN_BITS),
    .CODE_A (BW_WIDE),
    .CODE_B (BW_WIDE),
    .CODE_C (BW_MEDIUM)
  ) u_bw (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb   (bit_stb),
    .start     (clk_start),
    .fs_search (fs_search),
    .fs_found  (fs_found),
    .res_code  (cfg_bw_res),
    .code      (bw_code),
    .busy      (bw_busy)
  );

  acq_path #(
    .LEN_A  (LV_CLAMP_BITS),
    .LEN_B  (LV_LOSSY_BITS),
    .LEN_C  (0),
    .WIN    (LV_WIN_BITS),
    .CODE_A (LV_CLAMP),
    .CODE_B (LV_LOSSY),
    .CODE_C (LV_LOSSY)
  ) u_lvl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb   (bit_stb),
    .start     (lvl_start),
    .fs_search (fs_search),
    .fs_found  (fs_found),
    .res_code  (cfg_lvl_res),
    .code      (lvl_code),
    .busy      (lvl_busy)
  );

  AST_BW_RES_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    !bw_busy |-> (bw_code == cfg_bw_res)); // R11

  AST_LVL_RES_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_busy |-> (lvl_code == cfg_lvl_res)); // R11

  AST_LVL_APART: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_start && !lvl_start && !lvl_busy) |=> !lvl_busy); // R10

  AST_BW_APART: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_start && !clk_start && !bw_busy) |=> !bw_busy); // R10

endmodule

// File: tb/sim_acq_mode_seq.sv
module sim_acq_mode_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_stb = 1'b0, clk_start = 1'b0, lvl_start = 1'b0;
  logic       fs_search = 1'b0, fs_found = 1'b0;
  logic [1:0] cfg_bw_res = 2'd2, cfg_lvl_res = 2'd2;
  logic [1:0] bw_code, lvl_code;
  logic       bw_busy, lvl_busy;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  acq_mode_seq u0 (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .clk_start(clk_start),
    .lvl_start(lvl_start), .fs_search(fs_search), .fs_found(fs_found),
    .cfg_bw_res(cfg_bw_res), .cfg_lvl_res(cfg_lvl_res),
    .bw_code(bw_code), .bw_busy(bw_busy), .lvl_code(lvl_code), .lvl_busy(lvl_busy)
  );

  task automatic chk(input int got, input int exp, input string what);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  // strobes in cycles (a, b] when a strobe occurs every sp cycles
  function automatic int nstb(input int a, input int b, input int sp);
    return b / sp - a / sp;
  endfunction

  function automatic bit is_armed(input int st, input int srch, input int win, input int sp);
    if (srch < st) return 1'b0;
    if (srch == st) return 1'b1;
    return nstb(st, srch - 1, sp) < win;
  endfunction

  // 0 Wide, 1 Medium, 2 residual
  function automatic int bw_ph(input int i, input int st, input int srch, input int fnd, input int sp);
    int c;
    if (st < 0 || i < st) return 2;
    if (srch >= 0 && is_armed(st, srch, 14, sp)) begin
      if (fnd > st && fnd > srch && i >= fnd) return (nstb(fnd, i, sp) >= 30) ? 2 : 1;
      return 0;
    end
    c = nstb(st, i, sp);
    return (c < 16) ? 0 : (c < 46) ? 1 : 2;
  endfunction

  // 0 Clamp, 1 Lossy Peak, 2 residual
  function automatic int lv_ph(input int i, input int st, input int srch, input int fnd, input int sp);
    int c;
    if (st < 0 || i < st) return 2;
    c = nstb(st, i, sp);
    if (c < 1) return 0;
    if (srch >= 0 && is_armed(st, srch, 28, sp)) begin
      if (fnd > st && fnd > srch && nstb(st, fnd - 1, sp) >= 1 && i >= fnd) return 2;
      return 1;
    end
    return (c < 31) ? 1 : 2;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_stb = 0; clk_start = 0; lvl_start = 0; fs_search = 0; fs_found = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_case(input int b1, input int b2, input int l1, input int l2,
                          input int srch, input int fnd, input int sp, input int n,
                          input string tag);
    int bst, lst, bp, lp;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_stb   = (i % sp == 0);
      clk_start = (i == b1) || (i == b2);
      lvl_start = (i == l1) || (i == l2);
      fs_search = (i == srch);
      fs_found  = (i == fnd);
      @(posedge clk);
      #1;
      bst = (b2 >= 0 && i >= b2) ? b2 : b1;
      lst = (l2 >= 0 && i >= l2) ? l2 : l1;
      bp = bw_ph(i, bst, srch, fnd, sp);
      lp = lv_ph(i, lst, srch, fnd, sp);
      chk(bw_code, (bp == 2) ? int'(cfg_bw_res) : bp, $sformatf("%s bw_code cycle %0d", tag, i));
      chk(bw_busy, (bp != 2), $sformatf("%s bw_busy cycle %0d", tag, i));
      chk(lvl_code, (lp == 2) ? int'(cfg_lvl_res) : lp, $sformatf("%s lvl_code cycle %0d", tag, i));
      chk(lvl_busy, (lp != 2), $sformatf("%s lvl_busy cycle %0d", tag, i));
    end
    @(negedge clk);
    bit_stb = 0; clk_start = 0; lvl_start = 0; fs_search = 0; fs_found = 0;
  endtask

  initial begin
    do_reset();
    #1;
    // R1 reset state
    chk(bw_busy, 0, "R1 bw_busy after reset");
    chk(lvl_busy, 0, "R1 lvl_busy after reset");
    chk(bw_code, 2, "R1 bw_code after reset");
    chk(lvl_code, 2, "R1 lvl_code after reset");

    // R11 residual follows configuration
    for (int v = 0; v < 4; v++) begin
      @(negedge clk);
      cfg_bw_res = 2'(v); cfg_lvl_res = 2'(3 - v);
      #1;
      chk(bw_code, v, "R11 bw residual follows cfg");
      chk(lvl_code, 3 - v, "R11 lvl residual follows cfg");
    end
    @(negedge clk);
    cfg_bw_res = 2'd2; cfg_lvl_res = 2'd2;

    // R2 R3 R5 R6 R7 fixed schedules at several strobe spacings
    for (int sp = 1; sp <= 3; sp++) begin
      do_reset();
      run_case(0, -1, 0, -1, -1, -1, sp, 50 * sp + 10, "R2 R3 R5 R6 R7");
    end

    // R10 one path started alone
    do_reset();
    run_case(-1, -1, 0, -1, -1, -1, 2, 80, "R10 level only");
    do_reset();
    run_case(0, -1, -1, -1, -1, -1, 1, 60, "R10 bandwidth only");

    // R4 R8 R9 search offset sweep across both windows
    for (int c = 0; c <= 32; c++) begin
      do_reset();
      run_case(0, -1, 0, -1, c, 40, 1, 80, "R4 R8 R9 search sweep");
    end
    do_reset();
    run_case(3, -1, 3, -1, 9, 70, 2, 150, "R4 R8 spaced strobes");

    // R9 detection during Clamp, and detection with no search
    do_reset();
    run_case(0, -1, 0, -1, 0, 1, 1, 60, "R9 found in clamp");
    do_reset();
    run_case(0, -1, 0, -1, -1, 5, 1, 60, "R9 found unarmed");

    // R2 R6 restart mid schedule, with a Peak Averaging residual and a Hold bandwidth residual
    do_reset();
    cfg_bw_res = 2'd3;
    run_case(0, 20, 0, 25, -1, -1, 1, 90, "R2 R6 restart");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule